// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Three-Bit Instruction Decode

This block is the test access port of a memory device. It follows the IEEE 1149.1 protocol. A 16-state controller advances on the rising edge of the test clock under the mode-select input. A three-bit instruction register chooses which data register is placed between the serial input and the serial output. The choice is a one-bit bypass stage, a 32-bit identification register, or a parameterised boundary-scan chain.

On the core side, the block captures the pin ring in parallel into the boundary-scan chain. It holds a bank of update latches that can drive the output pins. It also raises two controls for the pad ring:
- a select that switches the output pins over to the update latches;
- a force-high-Z that tristates every device output.

The functional inputs are forwarded to the core without change, whatever instruction is active. A system test controller loads an instruction through an instruction scan. It then runs data scans to read the ID, to preload or observe the pins, or to drive the pins from the chain.

Top module: `tap_scan_port`

## Requirements
- R1: `rst` (synchronous, active high, sampled on rising `tck`) puts the controller in Test-Logic-Reset. Five consecutive rising `tck` edges with `tms`=1 also reach Test-Logic-Reset, from any state. In that state the current instruction becomes IDCODE (001).
- R2: During Capture-IR the instruction shift register loads 001. During Shift-IR it shifts toward `tdo` least significant bit first, with `tdi` entering at the top bit. The shifted value becomes the current instruction on the falling `tck` edge in Update-IR.
- R3: Under IDCODE (001), Capture-DR loads `ID_VALUE` into the 32-bit ID register. Shift-DR shifts that register from `tdi` to `tdo`, LSB first.
- R4: BYPASS (111), the reserved codes 011 and 110, and the private code 101 all select the one-bit bypass stage. That stage captures 0 in Capture-DR.
- R5: EXTEST (000), SAMPLE/PRELOAD (100) and SAMPLE-Z (010) select the `BSR_W`-bit boundary chain, LSB nearest `tdo`. Capture-DR loads `pin_in` into cells 0..`PIN_W`-1 and the matching `FILL` bits into the cells above.
- R6: `bs_select` is 1 exactly while EXTEST is the current instruction. It changes on the falling `tck` edge in Update-IR.
- R7: `force_hiz` is 1 exactly while SAMPLE-Z is the current instruction.
- R8: `bs_drive` loads the chain contents on the falling `tck` edge in Update-DR, but only when a boundary-chain instruction is current. Data scans under ID or bypass leave it unchanged.
- R9: `tdo` and `tdo_en` change on the falling `tck` edge. `tdo_en` is 1 only in Shift-IR and Shift-DR.
- R10: `core_in` always equals `pin_in`, including under EXTEST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset to Test-Logic-Reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out (valid when `tdo_en`) |
| tdo_en | output | 1 | Output enable for `tdo` |
| pin_in | input | PIN_W | Pin ring states for parallel capture |
| core_in | output | PIN_W | Functional inputs forwarded to the core |
| bs_drive | output | BSR_W | Boundary update latches toward the output pins |
| bs_select | output | 1 | Output pins take `bs_drive` instead of core data |
| force_hiz | output | 1 | Tristate every device output |

## Verification
The bench loads each of the eight opcodes in turn and then runs a 40-bit data scan. The pattern that comes back shows the length of the register in use, either 1, 32 or `BSR_W`, before the input pattern starts to reappear, and its first bits show the captured value. Bypass, ID and boundary chain therefore cannot be mistaken for one another, and a bad opcode alias shows up at once. The bench changes the pin pattern and the scan pattern with every opcode, so that capture of the wrong cells, fill bits in the wrong place, and update-latch loads under a non-chain instruction all show up. Directed scans then check the reset defaults, the escape to Test-Logic-Reset with mode-select held high in the middle of a data shift, and a reset applied while SAMPLE-Z is active.

// File: rtl/tap_pkg.sv
package tap_pkg;
  localparam int IR_W = 3;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [IR_W-1:0] {
    OP_EXTEST  = 3'b000,
    OP_IDCODE  = 3'b001,
    OP_SAMPLEZ = 3'b010,
    OP_RSV_A   = 3'b011,
    OP_SAMPLE  = 3'b100,
    OP_PRIV    = 3'b101,
    OP_RSV_B   = 3'b110,
    OP_BYPASS  = 3'b111
  } tap_op_e;
endpackage

// File: rtl/tap_ctrl.sv
module tap_ctrl
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  logic       tms,
  output tap_state_e state
);
  localparam int ESC_N = 5;
  localparam int CW    = $clog2(ESC_N + 1);

  tap_state_e nxt;
  logic [CW-1:0] ones_cnt;

  always_comb begin
    unique case (state)
      ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PA_DR;
      ST_PA_DR:  nxt = tms ? ST_EX2_DR : ST_PA_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PA_IR;
      ST_PA_IR:  nxt = tms ? ST_EX2_IR : ST_PA_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
      default:   nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge tck) begin
    if (rst) begin
      state    <= ST_RESET;
      ones_cnt <= '0;
    end else begin
      state    <= nxt;
      if (!tms)                 ones_cnt <= '0;
      else if (ones_cnt != CW'(ESC_N)) ones_cnt <= ones_cnt + 1'b1;
    end
  end

  // R1: five high mode-select clocks in a row always land in Test-Logic-Reset
  a_r1_five_ones_reset: assert property (@(posedge tck) disable iff (rst)
    (ones_cnt == CW'(ESC_N)) |-> (state == ST_RESET));
endmodule

// File: rtl/tap_instr.sv
module tap_instr
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  tap_state_e state,
  input  logic       tdi,
  output logic       ir_out,
  output logic       sel_id,
  output logic       sel_bsr,
  output logic       bs_select,
  output logic       force_hiz
);
  logic [IR_W-1:0] ir_sr;
  tap_op_e         ir_cur, ir_nxt;

  always_ff @(posedge tck) begin
    if (state == ST_CAP_IR)     ir_sr <= {{(IR_W-2){1'b0}}, 2'b01};
    else if (state == ST_SH_IR) ir_sr <= {tdi, ir_sr[IR_W-1:1]};
  end

  assign ir_out = ir_sr[0];

  always_comb begin
    if (state == ST_RESET)       ir_nxt = OP_IDCODE;
    else if (state == ST_UPD_IR) ir_nxt = tap_op_e'(ir_sr);
    else                         ir_nxt = ir_cur;
  end

  always_ff @(negedge tck) begin
    ir_cur    <= ir_nxt;
    sel_id    <= (ir_nxt == OP_IDCODE);
    sel_bsr   <= (ir_nxt == OP_EXTEST) || (ir_nxt == OP_SAMPLE) || (ir_nxt == OP_SAMPLEZ);
    bs_select <= (ir_nxt == OP_EXTEST);
    force_hiz <= (ir_nxt == OP_SAMPLEZ);
  end

  // R2: Capture-IR leaves the fixed 01 pattern in the low bits
  a_r2_ir_capture: assert property (@(posedge tck) disable iff (rst)
    (state == ST_CAP_IR) |=> (ir_sr[1:0] == 2'b01));
  // R6: the current instruction only moves in Update-IR or Test-Logic-Reset
  a_r6_ir_update_only: assert property (@(posedge tck) disable iff (rst)
    !$stable(ir_cur) |-> (state == ST_UPD_IR || state == ST_RESET));
endmodule

// File: rtl/tap_bscan.sv
module tap_bscan
  import tap_pkg::*;
#(
  parameter int               BSR_W = 10,
  parameter int               PIN_W = 8,
  parameter logic [BSR_W-1:0] FILL  = '0
) (
  input  logic             tck,
  input  logic             rst,
  input  tap_state_e       state,
  input  logic             sel_bsr,
  input  logic             tdi,
  input  logic [PIN_W-1:0] pin_in,
  output logic             bsr_out,
  output logic [BSR_W-1:0] bs_drive
);
  logic [BSR_W-1:0] cap_val;
  logic [BSR_W-1:0] chain;

  for (genvar g = 0; g < BSR_W; g++) begin : g_cell
    if (g < PIN_W) begin : g_pin
      assign cap_val[g] = pin_in[g];
    end else begin : g_fill
      assign cap_val[g] = FILL[g];
    end
  end

  always_ff @(posedge tck) begin
    if (sel_bsr) begin
      if (state == ST_CAP_DR)     chain <= cap_val;
      else if (state == ST_SH_DR) chain <= {tdi, chain[BSR_W-1:1]};
    end
  end

  assign bsr_out = chain[0];

  always_ff @(negedge tck) begin
    if (rst)                                  bs_drive <= '0;
    else if (sel_bsr && state == ST_UPD_DR)   bs_drive <= chain;
  end

  // R8: update latches move only in Update-DR
  a_r8_drive_on_update: assert property (@(posedge tck) disable iff (rst)
    !$stable(bs_drive) |-> (state == ST_UPD_DR));
endmodule

// File: rtl/tap_scan_port.sv
module tap_scan_port
  import tap_pkg::*;
#(
  parameter int               BSR_W    = 10,
  parameter int               PIN_W    = 8,
  parameter logic [BSR_W-1:0] FILL     = {2'b10, {(BSR_W-2){1'b0}}},
  parameter logic [31:0]      ID_VALUE = 32'h1B5C_7E93
) (
  input  logic             tck,
  input  logic             rst,
  input  logic             tms,
  input  logic             tdi,
  output logic             tdo,
  output logic             tdo_en,
  input  logic [PIN_W-1:0] pin_in,
  output logic [PIN_W-1:0] core_in,
  output logic [BSR_W-1:0] bs_drive,
  output logic             bs_select,
  output logic             force_hiz
);
  localparam int ID_W = 32;

  tap_state_e      state;
  logic            ir_out, bsr_out, sel_id, sel_bsr;
  logic            byp;
  logic [ID_W-1:0] id_sr;

  tap_ctrl u_ctrl (.tck(tck), .rst(rst), .tms(tms), .state(state));

  tap_instr u_instr (
    .tck(tck), .rst(rst), .state(state), .tdi(tdi), .ir_out(ir_out),
    .sel_id(sel_id), .sel_bsr(sel_bsr), .bs_select(bs_select), .force_hiz(force_hiz)
  );

  tap_bscan #(.BSR_W(BSR_W), .PIN_W(PIN_W), .FILL(FILL)) u_bscan (
    .tck(tck), .rst(rst), .state(state), .sel_bsr(sel_bsr), .tdi(tdi),
    .pin_in(pin_in), .bsr_out(bsr_out), .bs_drive(bs_drive)
  );

  // functional inputs pass through untouched by any instruction
  assign core_in = pin_in;

  always_ff @(posedge tck) begin
    if (state == ST_CAP_DR)     byp <= 1'b0;
    else if (state == ST_SH_DR) byp <= tdi;
    if (sel_id) begin
      if (state == ST_CAP_DR)     id_sr <= ID_VALUE;
      else if (state == ST_SH_DR) id_sr <= {tdi, id_sr[ID_W-1:1]};
    end
  end

  always_ff @(negedge tck) begin
    tdo_en <= (state == ST_SH_IR) || (state == ST_SH_DR);
    if (state == ST_SH_IR)  tdo <= ir_out;
    else if (sel_id)        tdo <= id_sr[0];
    else if (sel_bsr)       tdo <= bsr_out;
    else                    tdo <= byp;
  end

  // R9: the output enable, set on the falling edge, matches the shift states
  a_r9_tdo_en_shift: assert property (@(posedge tck) disable iff (rst)
    tdo_en == (state == ST_SH_IR || state == ST_SH_DR));
  // R4: bypass stage always holds 0 right after Capture-DR
  a_r4_bypass_zero: assert property (@(posedge tck) disable iff (rst)
    (state == ST_CAP_DR) |=> (byp == 1'b0));
endmodule

// File: tb/sim_tap_scan_port.sv
module sim_tap_scan_port;
  localparam int BSR_W = 10;
  localparam int PIN_W = 8;
  localparam logic [BSR_W-1:0] FILL = 10'b10_0000_0000;
  localparam logic [31:0] IDV = 32'h1B5C_7E93;
  localparam int NB = 40;

  // {opcode[6:4], kind[3:2] (0 bypass,1 id,2 chain), hiz[1], bsel[0]}
  localparam logic [6:0] VEC [8] = '{
    {3'b000, 2'd2, 1'b0, 1'b1},
    {3'b001, 2'd1, 1'b0, 1'b0},
    {3'b010, 2'd2, 1'b1, 1'b0},
    {3'b011, 2'd0, 1'b0, 1'b0},
    {3'b100, 2'd2, 1'b0, 1'b0},
    {3'b101, 2'd0, 1'b0, 1'b0},
    {3'b110, 2'd0, 1'b0, 1'b0},
    {3'b111, 2'd0, 1'b0, 1'b0}
  };

  logic tck = 1'b0, rst = 1'b1, tms = 1'b1, tdi = 1'b0;
  logic tdo, tdo_en, bs_select, force_hiz;
  logic [PIN_W-1:0] pin_in = '0, core_in;
  logic [BSR_W-1:0] bs_drive;
  int errors = 0, checks = 0;
  logic done = 1'b0;
  logic [NB-1:0] dout;
  logic [2:0] irgot;
  logic en_seen;

  always #10 tck = ~tck;

  tap_scan_port #(.BSR_W(BSR_W), .PIN_W(PIN_W), .FILL(FILL), .ID_VALUE(IDV)) u0 (
    .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
    .pin_in(pin_in), .core_in(core_in), .bs_drive(bs_drive),
    .bs_select(bs_select), .force_hiz(force_hiz)
  );

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic ir_scan(input logic [2:0] op);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 3; i++) begin
      irgot[i] = tdo;
      step(i == 2, op[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic dr_scan(input logic [NB-1:0] din);
    step(1, 0); step(0, 0); step(0, 0);
    en_seen = tdo_en;
    for (int i = 0; i < NB; i++) begin
      dout[i] = tdo;
      step(i == NB - 1, din[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  function automatic logic [NB-1:0] stream(input logic [NB-1:0] din, input int len, input logic [31:0] cap);
    logic [NB-1:0] e;
    for (int i = 0; i < NB; i++) begin
      if (i < len) e[i] = cap[i];
      else         e[i] = din[i - len];
    end
    return e;
  endfunction

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [BSR_W-1:0] drv_model;
    logic [NB-1:0] din;
    @(negedge tck); #1;
    step(1, 0); step(1, 0); step(1, 0);
    rst = 1'b0;
    // reset state (R1, R6, R7, R9)
    chk(tdo_en == 1'b0, "R9 reset tdo_en", tdo_en, 0);
    chk(bs_select == 1'b0 && force_hiz == 1'b0, "R6/R7 reset flags", {bs_select, force_hiz}, 0);
    chk(bs_drive == '0, "R8 reset drive", bs_drive, 0);
    step(0, 0);
    din = 40'hA5_0F0F_3C3C;
    dr_scan(din);
    chk(dout == stream(din, 32, IDV), "R1 default IDCODE after reset", dout, stream(din, 32, IDV));
    chk(tdo_en == 1'b0, "R9 tdo_en off in idle", tdo_en, 0);
    drv_model = '0;

    // table walk over all opcodes
    for (int v = 0; v < 8; v++) begin
      logic [2:0] op;
      logic [1:0] kind;
      logic [31:0] cap;
      int len;
      op = VEC[v][6:4]; kind = VEC[v][3:2];
      pin_in = 8'h5A + 8'(op * 17);
      din = 40'hC3_5A96_F01E ^ {37'd0, op} ^ (40'h1 << (v + 11));
      ir_scan(op);
      chk(irgot == 3'b001, "R2 IR capture pattern", irgot, 3'b001);
      chk(force_hiz == VEC[v][1], "R7 force_hiz per opcode", force_hiz, VEC[v][1]);
      chk(bs_select == VEC[v][0], "R6 bs_select per opcode", bs_select, VEC[v][0]);
      chk(core_in == pin_in, "R10 core inputs pass through", core_in, pin_in);
      if (kind == 2'd1)      begin len = 32;    cap = IDV; end
      else if (kind == 2'd2) begin len = BSR_W; cap = 32'({FILL[9:8], pin_in}); end
      else                   begin len = 1;     cap = 32'd0; end
      dr_scan(din);
      chk(en_seen == 1'b1, "R9 tdo_en in Shift-DR", en_seen, 1);
      chk(dout == stream(din, len, cap),
          kind == 2'd2 ? "R5 chain length and capture" : (kind == 2'd1 ? "R3 ID scan" : "R4 bypass scan"),
          dout, stream(din, len, cap));
      if (kind == 2'd2) drv_model = din[NB-1:NB-BSR_W];
      chk(bs_drive == drv_model, "R8 update latches", bs_drive, drv_model);
    end

    // escape to Test-Logic-Reset from the middle of a shift (R1)
    ir_scan(3'b000);
    chk(bs_select == 1'b1, "R6 EXTEST selected", bs_select, 1);
    step(1, 0); step(0, 0); step(0, 0); step(0, 1);
    chk(tdo_en == 1'b1, "R9 in shift before escape", tdo_en, 1);
    for (int k = 0; k < 5; k++) step(1, 0);
    chk(bs_select == 1'b0 && tdo_en == 1'b0, "R1 five TMS ones reach reset", {bs_select, tdo_en}, 0);
    step(0, 0);
    din = 40'h12_3456_789A;
    dr_scan(din);
    chk(dout == stream(din, 32, IDV), "R1 IDCODE after escape", dout, stream(din, 32, IDV));

    // synchronous reset while SAMPLE-Z is active (R1, R7)
    ir_scan(3'b010);
    chk(force_hiz == 1'b1, "R7 SAMPLE-Z active", force_hiz, 1);
    rst = 1'b1; step(0, 0); step(0, 0); rst = 1'b0;
    chk(force_hiz == 1'b0, "R7 reset clears force_hiz", force_hiz, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule